// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block manages the two low-power modes of a small microcontroller. Software writes a mode-select bit in a configuration register. The block then stops the system clock enable and disables the internal oscillators. In the deeper of the two modes it also switches off the core regulator and freezes the digital output pins. While either mode is active, the block watches a small set of wake events, each with its own enable bit. In shallow mode only, it also watches the external reset pin. When a wake event arrives, the block restores clocking and latches which sources caused the wake.

All wake inputs are synchronised through two flip-flops on the free-running always-on clock `clk`, and edge detection happens in that domain. The same clock times the two-clock window after a shallow wake, during which the wake flags read as zero. It also times the 16-cycle active-low wake request that tells external devices the chip has left the deep mode. Mode entry is refused unless the clock-source status input reports a permitted oscillator. The select bits clear themselves once the block wakes. No interface carries streaming data, so every pin is a plain control or status signal with no handshake.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset, `sys_clk_en`=1, `osc_dis`=0, `vreg_off`=0, `gpio_hold`=0 and `wake_req_n`=1, and both registers read 0x00.
- R2: Register map. `reg_addr`=0 is the configuration register: bits [4:0] enable the wake sources, bit 6 selects suspend, bit 7 selects sleep, and bit 5 reads 0. `reg_addr`=1 is the flag register: bits [4:0] are per-source flags and bit 5 is the reset-pin flag. Source index order on `wake_evt_raw`: 0 cap-sense conversion/scan done, 1 RTC oscillator fail, 2 RTC alarm, 3 port match, 4 comparator rising edge.
- R3: A configuration write with bit 6 set, while `clk_src_ok`=1, enters suspend on that clock edge: `sys_clk_en`=0, `osc_dis`=1, `vreg_off`=0, and configuration bit 6 reads 1.
- R4: A configuration write with bit 7 set, while `clk_src_ok`=1, enters sleep: `sys_clk_en`=0, `osc_dis`=1, `vreg_off`=1, `gpio_hold`=1. If bits 6 and 7 are both set, sleep is chosen.
- R5: With `clk_src_ok`=0, the select bits of a configuration write are ignored. The mode does not change and bits 7:6 read 0, while the enable bits are still written.
- R6: In either low-power mode, a rising edge on an enabled `wake_evt_raw` bit sets `sys_clk_en` back to 1 on the third clock edge after the input changes. A rising edge on a disabled source leaves the block asleep.
- R7: A falling edge on `rst_pin_n` wakes the block from suspend whatever the enable bits are, and sets flag bit 5. In sleep it has no effect.
- R8: On a wake, the block sets a flag for every enabled source whose edge arrived in the wake cycle. Events seen while running set no flag.
- R9: After a wake from suspend, the flag register reads 0x00 for two clocks and then shows the latched flags. After a wake from sleep, the flags are visible at once.
- R10: Writing 1 to a flag-register bit clears that flag. Bits written 0 are kept.
- R11: On wake, configuration bits 7:6 clear by themselves and the enable bits keep their value.
- R12: Leaving sleep drives `wake_req_n` low for exactly 16 clocks, starting on the wake edge. Leaving suspend never drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = wake flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| clk_src_ok | input | 1 | System clock comes from a permitted oscillator |
| wake_evt_raw | input | 5 | Asynchronous wake event inputs |
| rst_pin_n | input | 1 | Asynchronous external reset pin level |
| sys_clk_en | output | 1 | System clock gate enable |
| osc_dis | output | 1 | Internal oscillator disable |
| vreg_off | output | 1 | Core regulator off |
| gpio_hold | output | 1 | Freeze digital output pin states |
| wake_req_n | output | 1 | Active-low wake request to external devices |

## Verification
The bench covers every source in both modes, with its enable on and off. It expects a disabled source to leave the clock gated, so a design that ignored the enable mask would wake early. It reads the flag register on each of the clocks right after a suspend wake. A hidden window that is one clock too short or too long shows up as a nonzero or stale read, and so does a window wrongly applied after sleep. It also counts the low cycles of the wake request, sends simultaneous events, pulses the reset pin in both modes, and tries mode entry from a forbidden clock source. These checks catch a miscounted pulse, a lost flag when several sources fire together, a pin edge honoured in sleep, and a mode entered while the clock source was not allowed.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SUSP  = 2'd1,
    ST_SLEEP = 2'd2
  } lpm_state_e;

  localparam int CFG_SUSP_BIT  = 6;
  localparam int CFG_SLEEP_BIT = 7;
  localparam int REG_W         = 8;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int W       = 5,
  parameter int STAGES  = 2,
  parameter bit IDLE    = 1'b0,
  parameter bit FALLING = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] edge_o
);
  // pipe[0] is newest; pipe[STAGES-1] is the synchronised value, pipe[STAGES] its history
  logic [STAGES:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){{W{IDLE}}}};
    else        pipe <= {pipe[STAGES-1:0], d};
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = ~pipe[STAGES-1] & pipe[STAGES];
    end else begin : g_rise
      assign edge_o = pipe[STAGES-1] & ~pipe[STAGES];
    end
  endgenerate
endmodule

// File: rtl/lpm_flags.sv
module lpm_flags #(
  parameter int W    = 6,
  parameter int HIDE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         hide_start,
  output logic [W-1:0] flags_vis
);
  localparam int HW = $clog2(HIDE + 1);

  logic [W-1:0]  flags_q;
  logic [HW-1:0] hide_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      hide_q  <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_vec) | set_vec;
      if (hide_start)       hide_q <= HW'(HIDE);
      else if (hide_q != 0) hide_q <= hide_q - HW'(1);
    end
  end

  assign flags_vis = (hide_q == 0) ? flags_q : '0;

  // R8
  all_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  // R9
  hidden_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hide_start |=> (flags_vis == '0));
endmodule

// File: rtl/lpm_pulse.sv
module lpm_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse_n
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CW'(LEN);
    else if (cnt_q != 0) cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_n = (cnt_q == 0);

  // R12
  req_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !pulse_n);
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_SRC     = 5,
  parameter int SYNC_STAGES = 2,
  parameter int HIDE_CLKS   = 2,
  parameter int REQ_CLKS    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               clk_src_ok,
  input  logic [NUM_SRC-1:0] wake_evt_raw,
  input  logic               rst_pin_n,
  output logic               sys_clk_en,
  output logic               osc_dis,
  output logic               vreg_off,
  output logic               gpio_hold,
  output logic               wake_req_n
);
  localparam int NFLAG = NUM_SRC + 1;

  lpm_state_e         state_q, state_d;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] src_rise, src_hit;
  logic [0:0]         pin_fall;
  logic               pin_hit, wake_any;
  logic               cfg_wr, flag_wr;
  logic [NFLAG-1:0]   set_vec, clr_vec, flags_vis;

  lpm_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES), .IDLE(1'b0), .FALLING(1'b0)) u_src_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_evt_raw), .edge_o(src_rise));

  lpm_sync #(.W(1), .STAGES(SYNC_STAGES), .IDLE(1'b1), .FALLING(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(rst_pin_n), .edge_o(pin_fall));

  assign cfg_wr   = reg_wr && !reg_addr;
  assign flag_wr  = reg_wr && reg_addr;
  assign src_hit  = src_rise & en_q;
  assign pin_hit  = pin_fall[0] && (state_q == ST_SUSP);
  assign wake_any = (state_q != ST_RUN) && ((|src_hit) || pin_hit);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (cfg_wr && clk_src_ok) begin
          if (reg_wdata[CFG_SLEEP_BIT])     state_d = ST_SLEEP;
          else if (reg_wdata[CFG_SUSP_BIT]) state_d = ST_SUSP;
        end
      end
      default: if (wake_any) state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      en_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_wr && state_q == ST_RUN) en_q <= reg_wdata[NUM_SRC-1:0];
    end
  end

  assign set_vec = wake_any ? {pin_hit, src_hit} : '0;
  assign clr_vec = flag_wr ? reg_wdata[NFLAG-1:0] : '0;

  lpm_flags #(.W(NFLAG), .HIDE(HIDE_CLKS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .hide_start(wake_any && state_q == ST_SUSP), .flags_vis(flags_vis));

  lpm_pulse #(.LEN(REQ_CLKS)) u_req (
    .clk(clk), .rst_n(rst_n), .start(wake_any && state_q == ST_SLEEP),
    .pulse_n(wake_req_n));

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[NUM_SRC-1:0]  = en_q;
      reg_rdata[CFG_SUSP_BIT]  = (state_q == ST_SUSP);
      reg_rdata[CFG_SLEEP_BIT] = (state_q == ST_SLEEP);
    end else begin
      reg_rdata[NFLAG-1:0] = flags_vis;
    end
  end

  assign sys_clk_en = (state_q == ST_RUN);
  assign osc_dis    = (state_q != ST_RUN);
  assign vreg_off   = (state_q == ST_SLEEP);
  assign gpio_hold  = (state_q == ST_SLEEP);

  // R4
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vreg_off) |-> $past(cfg_wr && clk_src_ok && reg_wdata[CFG_SLEEP_BIT]));

  // R5
  refuse_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !clk_src_ok) |=> (state_q == ST_RUN));

  // R6
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_en) |-> $past(wake_any));

  // R12
  req_after_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_req_n) |-> $past(state_q == ST_SLEEP));
endmodule

// File: tb/lpm_wake_ctrl_tb.sv
module lpm_wake_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       clk_src_ok = 1'b1;
  logic [4:0] wake_evt_raw = '0;
  logic       rst_pin_n = 1'b1;
  logic       sys_clk_en, osc_dis, vreg_off, gpio_hold, wake_req_n;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lpm_wake_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_src_ok(clk_src_ok),
    .wake_evt_raw(wake_evt_raw), .rst_pin_n(rst_pin_n), .sys_clk_en(sys_clk_en),
    .osc_dis(osc_dis), .vreg_off(vreg_off), .gpio_hold(gpio_hold),
    .wake_req_n(wake_req_n));

  task automatic check(input string tag, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    wake_evt_raw = '0; rst_pin_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int lows;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {sys_clk_en, osc_dis, vreg_off, gpio_hold, wake_req_n}, 5'b10001);
    rd(0, v); check("R1 cfg", v, 0);
    rd(1, v); check("R1 flags", v, 0);

    // R2/R3/R4/R6/R9/R11/R12 sweep: each source, each mode, enable on/off
    for (int md = 0; md < 2; md++) begin
      for (int src = 0; src < 5; src++) begin
        for (int en = 0; en < 2; en++) begin
          logic [7:0] cmd;
          logic [7:0] ens;
          ens = en ? 8'(1 << src) : 8'h00;
          cmd = ens | (md ? 8'h80 : 8'h40);
          wr(0, cmd);
          rd(0, v);
          check(md ? "R4 sleep cfg read" : "R3 suspend cfg read", v, cmd);
          check(md ? "R4 sleep outputs" : "R3 suspend outputs",
                {sys_clk_en, osc_dis, vreg_off, gpio_hold}, md ? 4'b0111 : 4'b0100);
          wake_evt_raw[src] = 1'b1;
          @(negedge clk); @(negedge clk);
          check("R6 no early wake", sys_clk_en, 0);
          @(negedge clk);
          check("R6 wake timing/enable", sys_clk_en, en);
          if (en) begin
            rd(0, v); check("R11 select auto-clear", v, ens);
            if (md == 0) begin
              rd(1, v); check("R9 hidden clk1", v, 0);
              check("R12 no req after suspend", wake_req_n, 1);
              @(negedge clk); rd(1, v); check("R9 hidden clk2", v, 0);
              @(negedge clk); rd(1, v); check("R2/R9 flag visible", v, 1 << src);
            end else begin
              rd(1, v); check("R9 sleep flag immediate", v, 1 << src);
              lows = 0;
              while (!wake_req_n && lows < 40) begin lows++; @(negedge clk); end
              check("R12 req low cycles", lows, 16);
            end
            wr(1, 8'h3F);
            rd(1, v); check("R10 flags cleared", v, 0);
            wake_evt_raw = '0;
            repeat (4) @(negedge clk);
          end else begin
            do_reset();
          end
        end
      end
    end

    // R5 refused entry
    clk_src_ok = 1'b0;
    wr(0, 8'hC5);
    check("R5 stays running", {sys_clk_en, vreg_off}, 2'b10);
    rd(0, v); check("R5 select ignored, enables written", v, 8'h05);
    clk_src_ok = 1'b1;

    // R4 both select bits -> sleep
    wr(0, 8'hC0);
    check("R4 both bits pick sleep", {vreg_off, gpio_hold}, 2'b11);
    // R7 pin edge ignored in sleep
    rst_pin_n = 1'b0; repeat (2) @(negedge clk); rst_pin_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 pin no effect in sleep", {sys_clk_en, vreg_off}, 2'b01);
    do_reset();

    // R7 pin edge wakes suspend with all enables clear
    wr(0, 8'h40);
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 pin wakes suspend", sys_clk_en, 1);
    rst_pin_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(1, v); check("R7 pin flag bit5", v, 8'h20);
    wr(1, 8'h3F);

    // R8 simultaneous sources all captured, disabled one not
    wr(0, 8'h5D);
    wake_evt_raw = 5'b10111;
    repeat (5) @(negedge clk);
    rd(1, v); check("R8 multi capture", v, 8'h15);
    // R10 partial W1C
    wr(1, 8'h01);
    rd(1, v); check("R10 partial clear", v, 8'h14);
    wr(1, 8'h3F);
    wake_evt_raw = '0;
    repeat (4) @(negedge clk);

    // R8 running events not recorded
    wr(0, 8'h1F);
    wake_evt_raw = 5'b11111;
    repeat (5) @(negedge clk);
    rd(1, v); check("R8 no flags while running", v, 0);
    wake_evt_raw = '0;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule